// File: doc/BRIEF.md
# Power-Management Interrupt and Wake Aggregator

This block merges interrupt requests from eight peripheral functions into a single active-low system-management interrupt. It also merges wake events into a single active-low power-management-event output. Every source has a sticky status bit. That bit records an event whether or not the source is enabled. A per-source enable bit decides whether the status counts toward the output. A master bit then decides whether the merged interrupt reaches its pin. An extra interrupt term lets a keyboard-controller port line be routed into the group.

The wake side takes five sources. Four are asynchronous pin inputs: two ring-indicator lines, the keyboard clock and the mouse clock. Each passes through a two-flop synchronizer and a falling-edge detector. The fifth is a one-cycle valid-frame pulse from an infrared remote decoder. Each wake source has its own enable and sticky status, and a global wake enable gates the whole path.

Software reaches all registers through an indexed port: a 4-bit index, a write strobe with write data, and combinational read data. Both outputs are registered and are high out of reset.

Top module: `pm_event_hub`

## Requirements
- R1: After reset, every enable, control and status register reads 0, and both `smi_n` and `pme_n` are high.
- R2: A high `irq_req[i]` at a rising clock edge sets interrupt status bit i at that edge, whether or not the bit is enabled. Sources 0..4 (parallel, serial 2, serial 1, floppy, watchdog) map to bits 4:0 of index 0x2. Sources 5..7 (mouse, keyboard, infrared) map to bits 2:0 of index 0x3.
- R3: Status bits are sticky. A write of 1 to a bit at its status index clears it, and a write of 0 has no effect. A set and a clear in the same cycle leave the bit set.
- R4: `smi_n` goes low one clock after the status changes, when both of these hold: some status bit has its matching enable set, and the master bit (bit 7 of index 0x1) is 1. It returns high one clock after that condition ends. Enables for sources 0..4 sit in bits 4:0 of index 0x0, and enables for sources 5..7 sit in bits 2:0 of index 0x1.
- R5: While the master bit is 0, `smi_n` stays high whatever the status and enables hold.
- R6: With the route bit (bit 3 of index 0x1) set, a high `kbc_line` at a clock edge sets status bit 3 of index 0x3, and that bit joins the interrupt group. With the route bit clear, `kbc_line` is ignored.
- R7: A falling edge on `ri1_n`, `ri2_n`, `kb_clk` or `ms_clk` sets wake status bit 0, 1, 2 or 3 of index 0x6 at the third rising clock edge after the change, and not earlier. Rising edges set nothing.
- R8: A one-cycle `ir_frame` pulse sets wake status bit 4 at the clock edge where it is sampled.
- R9: `pme_n` goes low one clock after both of these hold: the global wake enable (bit 0 of index 0x4) is 1, and some wake status bit has its enable set in index 0x5. Wake status latches even while its enable or the global enable is clear.
- R10: Register bits without a function read 0, and reads of unused indexes (0x7 to 0xF) return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_req | input | 8 | Synchronous interrupt requests from the eight peripheral functions |
| kbc_line | input | 1 | Synchronous keyboard-controller port line that can be routed into the group |
| ri1_n | input | 1 | Asynchronous ring indicator 1, active low |
| ri2_n | input | 1 | Asynchronous ring indicator 2, active low |
| kb_clk | input | 1 | Asynchronous keyboard clock pin |
| ms_clk | input | 1 | Asynchronous mouse clock pin |
| ir_frame | input | 1 | Synchronous one-cycle pulse for a valid infrared remote frame |
| reg_idx | input | 4 | Register index |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for the register at `reg_idx` |
| smi_n | output | 1 | Group system-management interrupt, active low |
| pme_n | output | 1 | Power-management event, active low |

## Verification
The assertions assume that `irq_req`, `kbc_line`, `ir_frame` and the register port are synchronous to `clk`. Only the four wake pins may change at any time. The stimulus drives every input on the falling clock edge, so no input changes at a rising edge. The bench holds each pin level for several cycles so the synchronizers see clean edges. It pulses requests for exactly one cycle, except in the set-versus-clear case, where a request is held across a clearing write on purpose.

// File: rtl/pmh_pkg.sv
package pmh_pkg;
    localparam int DATA_W     = 8;
    localparam int IDX_W      = 4;
    localparam int NUM_IRQ    = 8;
    localparam int LO_CNT     = 5;
    localparam int HI_CNT     = NUM_IRQ - LO_CNT;
    localparam int GRP_W      = NUM_IRQ + 1;
    localparam int NUM_PIN    = 4;
    localparam int NUM_WAKE   = NUM_PIN + 1;
    localparam int ROUTE_BIT  = 3;
    localparam int MASTER_BIT = 7;
    localparam int GWEN_BIT   = 0;

    localparam logic [IDX_W-1:0] IDX_IEN_LO = 4'h0;
    localparam logic [IDX_W-1:0] IDX_IEN_HI = 4'h1;
    localparam logic [IDX_W-1:0] IDX_IST_LO = 4'h2;
    localparam logic [IDX_W-1:0] IDX_IST_HI = 4'h3;
    localparam logic [IDX_W-1:0] IDX_WCTL   = 4'h4;
    localparam logic [IDX_W-1:0] IDX_WEN    = 4'h5;
    localparam logic [IDX_W-1:0] IDX_WST    = 4'h6;

    typedef struct packed {
        logic [LO_CNT-1:0]   en_lo;
        logic [HI_CNT-1:0]   en_hi;
        logic                route;
        logic                master;
        logic                gwen;
        logic [NUM_WAKE-1:0] wen;
    } cfg_t;

    typedef struct packed {
        logic smi_n;
        logic pme_n;
    } out_t;
endpackage

// File: rtl/pmh_pin_edge.sv
module pmh_pin_edge #(
    parameter int          W      = 4,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] IDLE  = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] fall
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = pin;
        for (int s = 1; s < STAGES; s++) begin
            st_d.chain[s] = st_q.chain[s-1];
        end
        st_d.prev = st_q.chain[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= {STAGES{IDLE}};
            st_q.prev  <= IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < W; g++) begin : g_edge
        assign fall[g] = st_q.prev[g] & ~st_q.chain[LAST][g];
    end

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall != '0) |=> ((fall & $past(fall)) == '0));
endmodule

// File: rtl/pmh_sticky.sv
module pmh_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] sta
);
    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.bits = (st_q.bits & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sta = st_q.bits;

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((sta & $past(set)) == $past(set)));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sta & ~clr) != '0) |=> ((sta & $past(sta & ~clr)) == $past(sta & ~clr)));

    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set) != '0) |=> ((sta & $past(clr & ~set)) == '0));
endmodule

// File: rtl/pmh_regs.sv
module pmh_regs
    import pmh_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [GRP_W-1:0]    grp_sta,
    input  logic [NUM_WAKE-1:0] wake_sta,
    output logic [GRP_W-1:0]    grp_en,
    output logic                master,
    output logic                gwen,
    output logic [NUM_WAKE-1:0] wake_en,
    output logic [GRP_W-1:0]    grp_clr,
    output logic [NUM_WAKE-1:0] wake_clr,
    output logic [DATA_W-1:0]   reg_rdata
);
    cfg_t cfg_d, cfg_q;
    logic unused_wdata;

    always_comb begin
        cfg_d    = cfg_q;
        grp_clr  = '0;
        wake_clr = '0;
        if (reg_wr) begin
            case (reg_idx)
                IDX_IEN_LO: cfg_d.en_lo = reg_wdata[LO_CNT-1:0];
                IDX_IEN_HI: begin
                    cfg_d.en_hi  = reg_wdata[HI_CNT-1:0];
                    cfg_d.route  = reg_wdata[ROUTE_BIT];
                    cfg_d.master = reg_wdata[MASTER_BIT];
                end
                IDX_IST_LO: grp_clr[LO_CNT-1:0] = reg_wdata[LO_CNT-1:0];
                IDX_IST_HI: begin
                    grp_clr[NUM_IRQ-1:LO_CNT] = reg_wdata[HI_CNT-1:0];
                    grp_clr[NUM_IRQ]          = reg_wdata[ROUTE_BIT];
                end
                IDX_WCTL: cfg_d.gwen = reg_wdata[GWEN_BIT];
                IDX_WEN:  cfg_d.wen  = reg_wdata[NUM_WAKE-1:0];
                IDX_WST:  wake_clr   = reg_wdata[NUM_WAKE-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_idx)
            IDX_IEN_LO: reg_rdata[LO_CNT-1:0] = cfg_q.en_lo;
            IDX_IEN_HI: begin
                reg_rdata[HI_CNT-1:0] = cfg_q.en_hi;
                reg_rdata[ROUTE_BIT]  = cfg_q.route;
                reg_rdata[MASTER_BIT] = cfg_q.master;
            end
            IDX_IST_LO: reg_rdata[LO_CNT-1:0] = grp_sta[LO_CNT-1:0];
            IDX_IST_HI: begin
                reg_rdata[HI_CNT-1:0] = grp_sta[NUM_IRQ-1:LO_CNT];
                reg_rdata[ROUTE_BIT]  = grp_sta[NUM_IRQ];
            end
            IDX_WCTL: reg_rdata[GWEN_BIT]     = cfg_q.gwen;
            IDX_WEN:  reg_rdata[NUM_WAKE-1:0] = cfg_q.wen;
            IDX_WST:  reg_rdata[NUM_WAKE-1:0] = wake_sta;
            default: ;
        endcase
    end

    assign grp_en       = {cfg_q.route, cfg_q.en_hi, cfg_q.en_lo};
    assign master       = cfg_q.master;
    assign gwen         = cfg_q.gwen;
    assign wake_en      = cfg_q.wen;
    assign unused_wdata = &{1'b0, reg_wdata};

    // R10
    unused_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_idx > IDX_WST) |-> (reg_rdata == '0));
endmodule

// File: rtl/pm_event_hub.sv
module pm_event_hub
    import pmh_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_req,
    input  logic                kbc_line,
    input  logic                ri1_n,
    input  logic                ri2_n,
    input  logic                kb_clk,
    input  logic                ms_clk,
    input  logic                ir_frame,
    input  logic [IDX_W-1:0]    reg_idx,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                smi_n,
    output logic                pme_n
);
    logic [GRP_W-1:0]    grp_en, grp_clr, grp_set, grp_sta;
    logic [NUM_WAKE-1:0] wake_en, wake_clr, wake_set, wake_sta;
    logic [NUM_PIN-1:0]  pin_fall;
    logic                master, gwen;
    out_t                out_d, out_q;

    pmh_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_idx   (reg_idx),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .grp_sta   (grp_sta),
        .wake_sta  (wake_sta),
        .grp_en    (grp_en),
        .master    (master),
        .gwen      (gwen),
        .wake_en   (wake_en),
        .grp_clr   (grp_clr),
        .wake_clr  (wake_clr),
        .reg_rdata (reg_rdata)
    );

    pmh_pin_edge #(.W(NUM_PIN), .STAGES(2), .IDLE('1)) u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({ms_clk, kb_clk, ri2_n, ri1_n}),
        .fall  (pin_fall)
    );

    assign grp_set  = {kbc_line & grp_en[NUM_IRQ], irq_req};
    assign wake_set = {ir_frame, pin_fall};

    pmh_sticky #(.W(GRP_W)) u_grp_sta (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (grp_set),
        .clr   (grp_clr),
        .sta   (grp_sta)
    );

    pmh_sticky #(.W(NUM_WAKE)) u_wake_sta (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (wake_set),
        .clr   (wake_clr),
        .sta   (wake_sta)
    );

    always_comb begin
        out_d       = out_q;
        out_d.smi_n = ~(master & (|(grp_sta & grp_en)));
        out_d.pme_n = ~(gwen & (|(wake_sta & wake_en)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{smi_n: 1'b1, pme_n: 1'b1};
        else        out_q <= out_d;
    end

    assign smi_n = out_q.smi_n;
    assign pme_n = out_q.pme_n;

    // R5
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smi_n |-> $past(master));

    // R9
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pme_n |-> $past(gwen));

    // R6
    route_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(grp_sta[NUM_IRQ]) |-> $past(grp_en[NUM_IRQ]));
endmodule

// File: tb/pm_event_hub_tb.sv
`timescale 1ns/1ps
module pm_event_hub_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_req = '0;
    logic       kbc_line = 1'b0;
    logic       ri1_n = 1'b1, ri2_n = 1'b1, kb_clk = 1'b1, ms_clk = 1'b1;
    logic       ir_frame = 1'b0;
    logic [3:0] reg_idx = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       smi_n, pme_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    pm_event_hub u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .kbc_line(kbc_line),
        .ri1_n(ri1_n), .ri2_n(ri2_n), .kb_clk(kb_clk), .ms_clk(ms_clk),
        .ir_frame(ir_frame), .reg_idx(reg_idx), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smi_n(smi_n), .pme_n(pme_n)
    );

    // {req, en_lo, en_hi, exp_smi_n, exp_st_lo, exp_st_hi}
    localparam logic [40:0] VEC [8] = '{
        {8'h01, 8'h01, 8'h80, 1'b0, 8'h01, 8'h00},
        {8'h01, 8'h00, 8'h80, 1'b1, 8'h01, 8'h00},
        {8'h20, 8'h00, 8'h81, 1'b0, 8'h00, 8'h01},
        {8'h20, 8'h1F, 8'h01, 1'b1, 8'h00, 8'h01},
        {8'h90, 8'h10, 8'h80, 1'b0, 8'h10, 8'h04},
        {8'h80, 8'h1F, 8'h83, 1'b1, 8'h00, 8'h04},
        {8'hFF, 8'h00, 8'h84, 1'b0, 8'h1F, 8'h07},
        {8'h00, 8'h1F, 8'h87, 1'b1, 8'h00, 8'h00}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] i, input logic [7:0] d);
        @(negedge clk);
        reg_idx = i; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] i, input logic [7:0] exp);
        reg_idx = i;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        // R1 reset state
        chk("R1 smi_n", {7'd0, smi_n}, 8'h01);
        chk("R1 pme_n", {7'd0, pme_n}, 8'h01);
        for (int i = 0; i < 7; i++) rd_chk("R1 reg", 4'(i), 8'h00);

        // table walk: R2 R4 R5
        for (int v = 0; v < 8; v++) begin
            wr(4'h0, VEC[v][32:25]);
            wr(4'h1, VEC[v][24:17]);
            @(negedge clk); irq_req = VEC[v][40:33];
            @(negedge clk); irq_req = '0;
            @(negedge clk);
            chk($sformatf("R4/R5 smi_n vec%0d", v), {7'd0, smi_n}, {7'd0, VEC[v][16]});
            rd_chk($sformatf("R2 st_lo vec%0d", v), 4'h2, VEC[v][15:8]);
            rd_chk($sformatf("R2 st_hi vec%0d", v), 4'h3, VEC[v][7:0]);
            wr(4'h2, 8'hFF);
            wr(4'h3, 8'hFF);
            settle();
            chk($sformatf("R3 smi_n released vec%0d", v), {7'd0, smi_n}, 8'h01);
        end

        // R3 set wins over clear, write 0 ignored
        wr(4'h0, 8'h00); wr(4'h1, 8'h00);
        @(negedge clk); irq_req = 8'h01;
        wr(4'h2, 8'h01);
        irq_req = '0;
        rd_chk("R3 set wins", 4'h2, 8'h01);
        wr(4'h2, 8'h00);
        rd_chk("R3 write 0 ignored", 4'h2, 8'h01);
        wr(4'h2, 8'h01);
        rd_chk("R3 w1c", 4'h2, 8'h00);

        // R10 unused bits and indexes
        wr(4'h0, 8'hFF); wr(4'h1, 8'hFF); wr(4'h4, 8'hFF); wr(4'h5, 8'hFF);
        rd_chk("R10 ien_lo", 4'h0, 8'h1F);
        rd_chk("R10 ien_hi", 4'h1, 8'h8F);
        rd_chk("R10 wctl", 4'h4, 8'h01);
        rd_chk("R10 wen", 4'h5, 8'h1F);
        rd_chk("R10 idx7", 4'h7, 8'h00);
        rd_chk("R10 idxF", 4'hF, 8'h00);
        wr(4'h0, 8'h00); wr(4'h1, 8'h00); wr(4'h4, 8'h00); wr(4'h5, 8'h00);

        // R6 routing of kbc_line
        wr(4'h1, 8'h80);
        @(negedge clk); kbc_line = 1'b1;
        @(negedge clk); kbc_line = 1'b0;
        settle();
        chk("R6 route off smi_n", {7'd0, smi_n}, 8'h01);
        rd_chk("R6 route off status", 4'h3, 8'h00);
        wr(4'h1, 8'h88);
        @(negedge clk); kbc_line = 1'b1;
        @(negedge clk); kbc_line = 1'b0;
        settle();
        chk("R6 route on smi_n", {7'd0, smi_n}, 8'h00);
        rd_chk("R6 route on status", 4'h3, 8'h08);
        wr(4'h3, 8'h08);
        settle();
        chk("R6 cleared smi_n", {7'd0, smi_n}, 8'h01);
        wr(4'h1, 8'h00);

        // R7 synchronizer latency and R9 output
        wr(4'h5, 8'h1F); wr(4'h4, 8'h01);
        reg_idx = 4'h6;
        @(negedge clk); ri1_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd_chk("R7 not before third edge", 4'h6, 8'h00);
        @(negedge clk);
        rd_chk("R7 ri1 fall", 4'h6, 8'h01);
        chk("R9 pme_n one clock later (pre)", {7'd0, pme_n}, 8'h01);
        @(negedge clk);
        chk("R9 pme_n asserted", {7'd0, pme_n}, 8'h00);
        ri1_n = 1'b1;
        wr(4'h6, 8'h1F);
        repeat (4) @(negedge clk);
        rd_chk("R7 rising ignored", 4'h6, 8'h00);
        chk("R9 pme_n released", {7'd0, pme_n}, 8'h01);

        // R9 global enable and per-source enable
        @(negedge clk); ri2_n = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk("R7 ri2 fall", 4'h6, 8'h02);
        wr(4'h4, 8'h00);
        settle();
        chk("R9 global off", {7'd0, pme_n}, 8'h01);
        wr(4'h4, 8'h01);
        settle();
        chk("R9 global on", {7'd0, pme_n}, 8'h00);
        wr(4'h5, 8'h1D);
        settle();
        chk("R9 source off", {7'd0, pme_n}, 8'h01);
        wr(4'h6, 8'h1F);
        ri2_n = 1'b1;

        // R7 R9 clock pins latch while disabled
        wr(4'h5, 8'h00);
        repeat (3) @(negedge clk);
        kb_clk = 1'b0; ms_clk = 1'b0;
        repeat (4) @(negedge clk);
        rd_chk("R7 kb/ms fall latched", 4'h6, 8'h0C);
        chk("R9 disabled pme_n", {7'd0, pme_n}, 8'h01);
        kb_clk = 1'b1; ms_clk = 1'b1;
        wr(4'h6, 8'h1F);
        repeat (4) @(negedge clk);

        // R8 infrared frame pulse
        wr(4'h5, 8'h10);
        @(negedge clk); ir_frame = 1'b1;
        @(negedge clk); ir_frame = 1'b0;
        rd_chk("R8 ir frame", 4'h6, 8'h10);
        settle();
        chk("R8 ir pme_n", {7'd0, pme_n}, 8'h00);

        finish_run();
    end
endmodule